// File: doc/BRIEF.md
# Run-Merging Minimum Priority Queue

This block is a min-priority queue built from small sorted register banks and an on-chip key memory that stores sorted runs. Commands arrive on one port with a valid/ready handshake. The command is either an insert of a key or an extraction of the smallest stored key. An accepted extraction returns its key one cycle later with a valid flag. Every new key goes into the active input bank. When that bank reaches its size, two things happen. Its smallest key goes into the per-run head table, and the whole bank is copied into a free run slot of the memory at one key per cycle. In the meantime the second input bank takes over the inserts. An extraction compares the smallest run head with the smallest key of the active bank. It takes the head when the two are equal. When the key comes from a run, the head table is refilled from the next memory entry of that run. A run whose last key has been taken frees its slot.

The controller has three states. In IDLE it accepts both commands. It moves to DRAIN when an insert fills the active bank, and returns to IDLE after the last key of that bank has been copied. It moves from IDLE to MERGE when at most one run slot is free and two stored runs have at most one bank's worth of keys left between them. Those two runs are merged into a free slot in key order, one key per cycle. The controller returns to IDLE on the cycle that writes the last merged key. Inserts that do not fill a bank are still accepted during DRAIN and MERGE. Extractions and filling inserts wait for IDLE.

The capacity is (runs-1)*bank/2, which is 28 keys at the default sizes. At this occupancy two of the seven stored runs can always be merged, so a slot is always freed.

Top module: `pq_powered_top`

## Requirements
- R1: After reset the queue is empty. cmd_ready is high while cmd_op=0 (insert) and low while cmd_op=1 (extract), and res_valid is low.
- R2: An accepted extraction returns the smallest key held in the queue. Duplicates are kept, so equal keys come out once per insert.
- R3: While the queue is empty, cmd_ready stays low for cmd_op=1, and no result is produced.
- R4: While the queue holds 28 keys, cmd_ready stays low for cmd_op=0.
- R5: The insert that fills an input bank is accepted without waiting, and so is the insert right after it.
- R6: Once a bank has filled, extractions are held off until its 8 keys have been copied. An extraction presented in the cycle after the bank-filling insert and the following insert waits exactly 7 cycles.
- R7: res_valid is high for exactly one cycle, in the cycle after each accepted extraction, and at no other time.
- R8: An insert with fewer than 28 keys stored, or an extraction with keys stored, is accepted within 40 cycles. Background merging reclaims run slots so that the full capacity stays reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 1 | 0 = insert, 1 = extract minimum |
| cmd_key | input | KW | Key to insert |
| cmd_ready | output | 1 | Command with the present cmd_op is taken at this edge |
| res_valid | output | 1 | res_key holds an extracted key |
| res_key | output | KW | Extracted minimum key |

## Verification
Two things can happen in the same cycle: a plain insert into the active bank, and a background write of the memory by DRAIN or MERGE. The bench provokes this in two ways. It sends inserts directly behind a filling insert, and it runs long random mixes, weighted toward inserts and then toward extractions, over a narrow key range with many duplicates. This keeps runs being created, partly consumed and merged while new keys arrive. The outcome is judged at the result port. Every extracted key must equal the minimum of an independent reference queue, and no accepted command may ever go missing or time out.

// File: rtl/pq_powered_pkg.sv
package pq_powered_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_MERGE = 2'd2
    } pq_state_e;

    localparam logic OP_INSERT  = 1'b0;
    localparam logic OP_EXTRACT = 1'b1;
endpackage

// File: rtl/pq_sorted_bank.sv
module pq_sorted_bank #(
    parameter int KW    = 16,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ins,
    input  logic [KW-1:0]               ins_key,
    input  logic                        pop,
    input  logic                        clr,
    output logic [PW-1:0]               cnt,
    output logic [DEPTH-1:0][KW-1:0]    keys
);
    logic [PW-1:0]            pos;
    logic [DEPTH-1:0][KW-1:0] up_sh, dn_sh, nxt;

    // insertion point: after every stored key that is <= the new key
    always_comb begin
        pos = '0;
        for (int i = 0; i < DEPTH; i++)
            if (PW'(i) < cnt && keys[i] <= ins_key) pos = pos + 1'b1;
    end

    assign up_sh = {keys[DEPTH-2:0], KW'(0)};
    assign dn_sh = {KW'(0), keys[DEPTH-1:1]};

    always_comb begin
        nxt = keys;
        for (int i = 0; i < DEPTH; i++) begin
            if (ins) begin
                if (PW'(i) == pos)     nxt[i] = ins_key;
                else if (PW'(i) > pos) nxt[i] = up_sh[i];
            end else if (pop) begin
                nxt[i] = dn_sh[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            keys <= '0;
        end else begin
            keys <= nxt;
            if (clr)      cnt <= '0;
            else if (ins) cnt <= cnt + 1'b1;
            else if (pop) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/pq_head_pick.sv
module pq_head_pick #(
    parameter int KW   = 16,
    parameter int NRUN = 8,
    localparam int RW  = $clog2(NRUN)
) (
    input  logic [NRUN-1:0]          used,
    input  logic [NRUN-1:0][KW-1:0]  heads,
    output logic                     any,
    output logic [RW-1:0]            idx,
    output logic [KW-1:0]            min_key
);
    always_comb begin
        any     = 1'b0;
        idx     = '0;
        min_key = '0;
        for (int i = 0; i < NRUN; i++) begin
            if (used[i] && (!any || heads[i] < min_key)) begin
                any     = 1'b1;
                idx     = RW'(i);
                min_key = heads[i];
            end
        end
    end
endmodule

// File: rtl/pq_run_alloc.sv
module pq_run_alloc #(
    parameter int NRUN = 8,
    parameter int BQ   = 8,
    localparam int RW  = $clog2(NRUN),
    localparam int PW  = $clog2(BQ + 1),
    localparam int SW  = PW + 1
) (
    input  logic [NRUN-1:0]          used,
    input  logic [NRUN-1:0][PW-1:0]  rd,
    input  logic [NRUN-1:0][PW-1:0]  fin,
    output logic                     free2,
    output logic [RW-1:0]            free_idx,
    output logic                     pair_ok,
    output logic [RW-1:0]            pair_a,
    output logic [RW-1:0]            pair_b
);
    logic [NRUN-1:0][SW-1:0] rem;

    always_comb begin
        for (int i = 0; i < NRUN; i++) rem[i] = SW'(fin[i]) - SW'(rd[i]);
    end

    always_comb begin
        free_idx = '0;
        free2    = 1'b0;
        for (int i = NRUN - 1; i >= 0; i--)
            if (!used[i]) free_idx = RW'(i);
        free2 = ($countones(~used) >= 2);
    end

    always_comb begin
        pair_ok = 1'b0;
        pair_a  = '0;
        pair_b  = '0;
        for (int i = 0; i < NRUN; i++)
            for (int j = i + 1; j < NRUN; j++)
                if (!pair_ok && used[i] && used[j] && (rem[i] + rem[j] <= SW'(BQ))) begin
                    pair_ok = 1'b1;
                    pair_a  = RW'(i);
                    pair_b  = RW'(j);
                end
    end
endmodule

// File: rtl/pq_powered_top.sv
module pq_powered_top
    import pq_powered_pkg::*;
#(
    parameter int KW   = 16,
    parameter int BQ   = 8,
    parameter int NRUN = 8,
    parameter int RAMD = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_op,
    input  logic [KW-1:0] cmd_key,
    output logic          cmd_ready,
    output logic          res_valid,
    output logic [KW-1:0] res_key
);
    localparam int CAP = (NRUN - 1) * BQ / 2;
    localparam int RW  = $clog2(NRUN);
    localparam int PW  = $clog2(BQ + 1);
    localparam int QW  = $clog2(BQ);
    localparam int AW  = $clog2(RAMD);
    localparam int CW  = $clog2(CAP + 1);

    pq_state_e state, state_nx;
    logic                    act;
    logic [CW-1:0]           occ;
    logic [NRUN-1:0]         run_used;
    logic [NRUN-1:0][PW-1:0] run_rd, run_end;
    logic [NRUN-1:0][KW-1:0] head_key;
    logic [KW-1:0]           ram [RAMD];

    logic [QW-1:0] dr_idx;
    logic [RW-1:0] dr_slot, m_a, m_b, m_dst;
    logic [PW-1:0] m_pa, m_pb, m_w;
    logic [KW-1:0] m_head;

    logic [1:0]                        bank_ins, bank_pop, bank_clr;
    logic [PW-1:0]                     bank_cnt  [2];
    logic [BQ-1:0][KW-1:0]             bank_keys [2];

    function automatic logic [AW-1:0] slot_addr(input logic [RW-1:0] r, input logic [PW-1:0] off);
        return AW'(int'(r) * BQ + int'(off));
    endfunction

    for (genvar b = 0; b < 2; b++) begin : g_bank
        pq_sorted_bank #(.KW(KW), .DEPTH(BQ)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .ins(bank_ins[b]), .ins_key(cmd_key), .pop(bank_pop[b]), .clr(bank_clr[b]),
            .cnt(bank_cnt[b]), .keys(bank_keys[b])
        );
    end

    logic          ex_any;
    logic [RW-1:0] ex_idx;
    logic [KW-1:0] ex_min;
    pq_head_pick #(.KW(KW), .NRUN(NRUN)) u_pick (
        .used(run_used), .heads(head_key), .any(ex_any), .idx(ex_idx), .min_key(ex_min)
    );

    logic          free2, pair_ok;
    logic [RW-1:0] free_idx, pr_a, pr_b;
    pq_run_alloc #(.NRUN(NRUN), .BQ(BQ)) u_alloc (
        .used(run_used), .rd(run_rd), .fin(run_end),
        .free2(free2), .free_idx(free_idx), .pair_ok(pair_ok), .pair_a(pr_a), .pair_b(pr_b)
    );

    logic [PW-1:0] act_cnt, nrd;
    logic [KW-1:0] act_min, fill_min, m_ka, m_kb, m_key;
    logic in_any, filling, merge_want, ins_ok, ext_ok, do_ins, do_ext, take_exit;
    logic m_va, m_vb, m_take_a, m_last, drain_last;

    assign act_cnt    = bank_cnt[act];
    assign act_min    = bank_keys[act][0];
    assign in_any     = (act_cnt != '0);
    assign filling    = (act_cnt == PW'(BQ - 1));
    assign merge_want = (state == ST_IDLE) && !free2 && pair_ok;
    assign ins_ok     = (occ < CW'(CAP)) && (!filling || ((state == ST_IDLE) && free2));
    assign ext_ok     = (occ != '0) && (state == ST_IDLE) && !merge_want;
    assign cmd_ready  = (cmd_op == OP_EXTRACT) ? ext_ok : ins_ok;
    assign do_ins     = cmd_valid && (cmd_op == OP_INSERT) && ins_ok;
    assign do_ext     = cmd_valid && (cmd_op == OP_EXTRACT) && ext_ok;
    assign take_exit  = ex_any && (!in_any || ex_min <= act_min);
    assign fill_min   = (act_min <= cmd_key) ? act_min : cmd_key;
    assign nrd        = run_rd[ex_idx] + 1'b1;
    assign drain_last = (dr_idx == QW'(BQ - 1));

    assign bank_ins = {do_ins && act, do_ins && !act};
    assign bank_pop = {do_ext && !take_exit && act, do_ext && !take_exit && !act};
    assign bank_clr = {(state == ST_DRAIN) && drain_last && !act,
                       (state == ST_DRAIN) && drain_last && act};

    // merge datapath: two run cursors feeding one ordered write stream
    assign m_ka     = ram[slot_addr(m_a, m_pa)];
    assign m_kb     = ram[slot_addr(m_b, m_pb)];
    assign m_va     = (m_pa < run_end[m_a]);
    assign m_vb     = (m_pb < run_end[m_b]);
    assign m_take_a = m_va && (!m_vb || m_ka <= m_kb);
    assign m_key    = m_take_a ? m_ka : m_kb;
    assign m_last   = m_take_a ? ((m_pa + 1'b1 == run_end[m_a]) && !m_vb)
                               : ((m_pb + 1'b1 == run_end[m_b]) && !m_va);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (do_ins && filling) state_nx = ST_DRAIN;
                      else if (merge_want)   state_nx = ST_MERGE;
            ST_DRAIN: if (drain_last)        state_nx = ST_IDLE;
            ST_MERGE: if (m_last)            state_nx = ST_IDLE;
            default:                         state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // key memory: written by DRAIN (bank copy) or MERGE (ordered stream)
    always_ff @(posedge clk) begin
        if (state == ST_DRAIN)
            ram[slot_addr(dr_slot, PW'(dr_idx))] <= bank_keys[!act][dr_idx];
        else if (state == ST_MERGE)
            ram[slot_addr(m_dst, m_w)] <= m_key;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act       <= 1'b0;
            occ       <= '0;
            run_used  <= '0;
            run_rd    <= '0;
            run_end   <= '0;
            head_key  <= '0;
            res_valid <= 1'b0;
            res_key   <= '0;
            dr_idx    <= '0;
            dr_slot   <= '0;
            m_a       <= '0;
            m_b       <= '0;
            m_dst     <= '0;
            m_pa      <= '0;
            m_pb      <= '0;
            m_w       <= '0;
            m_head    <= '0;
        end else begin
            res_valid <= do_ext;
            if (do_ext) res_key <= take_exit ? ex_min : act_min;
            if (do_ins)      occ <= occ + 1'b1;
            else if (do_ext) occ <= occ - 1'b1;

            if (do_ext && take_exit) begin
                if (nrd == run_end[ex_idx]) begin
                    run_used[ex_idx] <= 1'b0;
                end else begin
                    run_rd[ex_idx]   <= nrd;
                    head_key[ex_idx] <= ram[slot_addr(ex_idx, nrd)];
                end
            end

            if (do_ins && filling) begin
                run_used[free_idx] <= 1'b1;
                run_rd[free_idx]   <= '0;
                run_end[free_idx]  <= PW'(BQ);
                head_key[free_idx] <= fill_min;
                dr_slot            <= free_idx;
                dr_idx             <= '0;
                act                <= !act;
            end
            if (state == ST_DRAIN) dr_idx <= dr_idx + 1'b1;

            if (merge_want) begin
                m_a            <= pr_a;
                m_b            <= pr_b;
                m_pa           <= run_rd[pr_a];
                m_pb           <= run_rd[pr_b];
                m_dst          <= free_idx;
                m_w            <= '0;
                run_used[pr_a] <= 1'b0;
                run_used[pr_b] <= 1'b0;
            end
            if (state == ST_MERGE) begin
                m_w <= m_w + 1'b1;
                if (m_take_a) m_pa <= m_pa + 1'b1;
                else          m_pb <= m_pb + 1'b1;
                if (m_w == '0) m_head <= m_key;
                if (m_last) begin
                    run_used[m_dst] <= 1'b1;
                    run_rd[m_dst]   <= '0;
                    run_end[m_dst]  <= m_w + 1'b1;
                    head_key[m_dst] <= (m_w == '0) ? m_key : m_head;
                end
            end
        end
    end
endmodule

// File: rtl/pq_powered_chk.sv
module pq_powered_chk
    import pq_powered_pkg::*;
#(
    parameter int NRUN = 8,
    parameter int CW   = 5,
    parameter int CAP  = 28
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_op,
    input logic            cmd_ready,
    input logic            res_valid,
    input logic [CW-1:0]   occ,
    input logic [NRUN-1:0] run_used,
    input pq_state_e       state
);
    // R7
    res_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(cmd_valid && cmd_op && cmd_ready));

    // R7
    res_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op && cmd_ready) |=> res_valid);

    // R3
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !(cmd_op && cmd_ready));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ >= CW'(CAP)) |-> !(!cmd_op && cmd_ready));

    // R6
    drain_noext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> !(cmd_op && cmd_ready));

    // R8
    slot_reserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> ($countones(run_used) <= NRUN - 1));
endmodule

bind pq_powered_top pq_powered_chk #(.NRUN(NRUN), .CW(CW), .CAP(CAP)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .res_valid(res_valid), .occ(occ),
    .run_used(run_used), .state(state)
);

// File: tb/tb_pq_powered_top.sv
module tb_pq_powered_top;
    localparam int CLK_PERIOD = 10;
    localparam int KW   = 16;
    localparam int BQ   = 8;
    localparam int NRUN = 8;
    localparam int RAMD = 64;
    localparam int CAP  = (NRUN - 1) * BQ / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_op = 1'b0;
    logic [KW-1:0] cmd_key = '0;
    logic          cmd_ready, res_valid;
    logic [KW-1:0] res_key;

    pq_powered_top #(.KW(KW), .BQ(BQ), .NRUN(NRUN), .RAMD(RAMD)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_key(cmd_key), .cmd_ready(cmd_ready), .res_valid(res_valid), .res_key(res_key)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int ref_q[$];
    int exp_q[$];

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // monitor: compare every result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected result", int'(res_key), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(res_key) == e, "R2 extracted key", int'(res_key), e);
            end
        end
    end

    // driver: present one command, wait up to maxw cycles for acceptance
    task automatic do_op(input logic op, input int key, input int maxw,
                         output bit acc, output int waits);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_key   = KW'(key);
        acc       = 1'b0;
        waits     = 0;
        while (waits < maxw) begin
            #1;
            if (cmd_ready) begin
                acc = 1'b1;
                break;
            end
            @(negedge clk);
            waits++;
        end
        if (acc) begin
            if (op == 1'b0) begin
                ref_q.push_back(key);
                ref_q.sort();
            end else begin
                exp_q.push_back(ref_q.pop_front());
            end
            @(posedge clk);
            #1;
        end
        cmd_valid = 1'b0;
    endtask

    task automatic checked_op(input logic op, input int key);
        bit acc;
        int w;
        if (op == 1'b0) begin
            if (ref_q.size() < CAP) begin
                do_op(1'b0, key, 40, acc, w);
                check(acc, "R8 insert accepted", int'(acc), 1);
            end else begin
                do_op(1'b0, key, 3, acc, w);
                check(!acc, "R4 insert refused at capacity", int'(acc), 0);
            end
        end else begin
            if (ref_q.size() > 0) begin
                do_op(1'b1, 0, 40, acc, w);
                check(acc, "R8 extract accepted", int'(acc), 1);
            end else begin
                do_op(1'b1, 0, 3, acc, w);
                check(!acc, "R3 extract refused when empty", int'(acc), 0);
            end
        end
    endtask

    task automatic drain_all();
        while (ref_q.size() > 0) checked_op(1'b1, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        bit acc;
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        cmd_op = 1'b1;
        #1;
        check(cmd_ready == 1'b0, "R1 extract ready after reset", int'(cmd_ready), 0);
        cmd_op = 1'b0;
        #1;
        check(cmd_ready == 1'b1, "R1 insert ready after reset", int'(cmd_ready), 1);
        check(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);

        // R3: extraction from empty queue refused
        do_op(1'b1, 0, 6, acc, w);
        check(!acc, "R3 empty extract", int'(acc), 0);

        // R5: fill one bank with descending keys, no waiting
        for (int i = 0; i < BQ; i++) begin
            do_op(1'b0, 500 - 10 * i, 4, acc, w);
            check(acc && w == 0, "R5 insert no wait", w, 0);
        end
        do_op(1'b0, 777, 4, acc, w);
        check(acc && w == 0, "R5 insert after fill", w, 0);

        // R6: extraction held off while the full bank is copied
        do_op(1'b1, 0, 40, acc, w);
        check(acc && w == BQ - 1, "R6 extract wait during copy", w, BQ - 1);
        drain_all();

        // R4/R8: fill to capacity with ties, then one refused insert
        for (int i = 0; i < CAP; i++) checked_op(1'b0, (i * 7) % 5);
        check(ref_q.size() == CAP, "R8 capacity reached", ref_q.size(), CAP);
        checked_op(1'b0, 3);
        drain_all();

        // random mixes with shifting insert bias and key range
        for (int seg = 0; seg < 6; seg++) begin
            int bias;
            int span;
            bias = (seg % 3 == 0) ? 75 : ((seg % 3 == 1) ? 35 : 55);
            span = (seg < 3) ? 16 : 65536;
            for (int n = 0; n < 600; n++) begin
                if (($urandom % 100) < bias) checked_op(1'b0, int'($urandom % span));
                else                         checked_op(1'b1, 0);
            end
        end
        drain_all();

        // R7: nothing left outstanding
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7 results all delivered", exp_q.size(), 0);
        finish_run();
    end
endmodule